// File: doc/BRIEF.md
# Base-Index-Displacement Operand Address Generator

This block turns a fetched 4-byte or 6-byte instruction into the logical addresses of its storage operands. It holds sixteen 32-bit general registers. An instruction presented with its strobe is decoded in the same cycle. Its base, index and displacement fields are pulled out, and each address is formed as the base register contents plus the index register contents plus a zero-extended 12-bit displacement. The result is registered, so it appears one clock after the instruction.

A register field of zero stands for "no register" and adds nothing to the sum. This holds whatever register 0 currently contains. The same adder also gives the full 32-bit sum. Instructions that use the computed value as a plain number, such as a shift count, read that sum instead of the 24-bit address. For storage-to-storage instructions, both operand addresses and the length byte appear together in one cycle. A synchronous write port lets the surrounding logic or a bench preload the registers.

Top module: `operand_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first instruction, every output is zero, including both valid strobes.
- R2: The format comes from opcode bits [7:6]: 00 register-only, 01 indexed storage, 10 register-storage (no index), 11 storage-storage. `fmtOut` takes the format of every instruction accepted with `instValid`.
- R3: In the indexed format, the index field is instruction bits [35:32], the base field is bits [31:28] and the displacement is bits [27:16]. `addr2` is the low 24 bits of index contents plus base contents plus displacement.
- R4: A base or index field equal to 0 adds zero, even when register 0 holds a nonzero value.
- R5: A displacement is always treated as unsigned, so 0xFFF adds 4095 and is never sign-extended.
- R6: The sum is formed at 32 bits and `rawSum` carries it modulo 2^32. `addr2` equals the low 24 bits of `rawSum`, and carries out of bit 23 are dropped.
- R7: In the register-storage format, bits [35:32] name a register operand and are never added. The address is base (bits [31:28]) plus displacement (bits [27:16]), and `rawSum` gives it as a count.
- R8: In the storage-storage format, `addr1` is base [31:28] plus displacement [27:16], `addr2` is base [15:12] plus displacement [11:0], and `lenOut` is bits [39:32]. All three appear in the same cycle, with `ssValid` and `opValid` both high.
- R9: A register-only instruction, or a cycle without `instValid`, drives `opValid` and `ssValid` low. In such a cycle `addr1`, `addr2`, `rawSum` and `lenOut` keep their values.
- R10: The results of an instruction accepted at clock edge k are visible after edge k and before edge k+1. `opValid` is high for exactly that one cycle per address-producing instruction.
- R11: A register write takes effect at the clock edge. An instruction accepted at the same edge uses the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | 4 | Register number to write |
| wrData | input | 32 | Value to write |
| instValid | input | 1 | Instruction present this cycle |
| instWord | input | 48 | Instruction bytes, first byte in [47:40]; 4-byte forms use [47:16] |
| opValid | output | 1 | An address result is present |
| ssValid | output | 1 | Both operand addresses are present (storage-storage) |
| fmtOut | output | 2 | Format of the last accepted instruction |
| addr1 | output | 24 | First operand address (storage-storage only) |
| addr2 | output | 24 | Second operand address, or the only address |
| rawSum | output | 32 | Full 32-bit sum behind `addr2` |
| lenOut | output | 8 | Length byte of the last storage-storage instruction |

## Verification
Worked register and displacement combinations with known hand-computed addresses check that the correct nibbles are picked as base and index. A nonzero value written into register 0 separates a design that honours the zero rule from one that reads the register. Register values near 2^24 and 2^32 check that the 24-bit address wraps and the 32-bit sum keeps its upper bits. An RS instruction whose second register nibble names a loaded register catches a design that adds an index there. Register-only, idle and same-edge write cycles, mixed with a long random stream, are compared every clock against a behavioural model. This shows that results hold and that reads see the register value from before the write.

// File: rtl/oag_pkg.sv
package oag_pkg;
  localparam int INST_BITS = 48;
  localparam int DISP_W    = 12;
  localparam int FIELD_W   = 4;

  typedef enum logic [1:0] {
    FMT_RR = 2'b00,
    FMT_RX = 2'b01,
    FMT_RS = 2'b10,
    FMT_SS = 2'b11
  } fmt_e;

  typedef struct packed {
    logic load;       // an instruction is accepted
    logic addrValid;  // it produces at least one address
    logic useIndex;   // add the index term
    logic dualAddr;   // two operand addresses
    fmt_e fmt;
  } ctrl_s;
endpackage

// File: rtl/oag_ctrl.sv
module oag_ctrl
  import oag_pkg::*;
(
  input  logic       instValid,
  input  logic [7:0] opcode,
  output ctrl_s      strb
);
  fmt_e decFmt;

  always_comb begin
    decFmt         = fmt_e'(opcode[7:6]);
    strb.fmt       = decFmt;
    strb.load      = instValid;
    strb.addrValid = instValid && (decFmt != FMT_RR);
    strb.useIndex  = (decFmt == FMT_RX);
    strb.dualAddr  = instValid && (decFmt == FMT_SS);
  end
endmodule

// File: rtl/oag_dpath.sv
module oag_dpath
  import oag_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 24,
  parameter int NREGS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [FIELD_W-1:0] wrIdx,
  input  logic [REG_W-1:0]  wrData,
  input  logic [39:0]       instBody,
  input  ctrl_s             strb,
  output logic              opValid,
  output logic              ssValid,
  output logic [1:0]        fmtOut,
  output logic [ADDR_W-1:0] addr1,
  output logic [ADDR_W-1:0] addr2,
  output logic [REG_W-1:0]  rawSum,
  output logic [7:0]        lenOut
);
  localparam int EXT_W = REG_W - DISP_W;

  logic [REG_W-1:0] gpr [NREGS];

  logic [FIELD_W-1:0] idxField, baseA, baseB;
  logic [DISP_W-1:0]  dispA, dispB;
  logic [REG_W-1:0]   dispAExt, dispBExt, idxTerm, baseATerm, baseBTerm;
  logic [REG_W-1:0]   sumA, sumB;

  function automatic logic [REG_W-1:0] readTerm(input logic [FIELD_W-1:0] sel);
    readTerm = (sel == '0) ? '0 : gpr[sel];
  endfunction

  always_comb begin
    idxField  = instBody[35:32];
    baseA     = instBody[31:28];
    dispA     = instBody[27:16];
    baseB     = instBody[15:12];
    dispB     = instBody[11:0];
    dispAExt  = {{EXT_W{1'b0}}, dispA};
    dispBExt  = {{EXT_W{1'b0}}, dispB};
    idxTerm   = strb.useIndex ? readTerm(idxField) : '0;
    baseATerm = readTerm(baseA);
    baseBTerm = readTerm(baseB);
    sumA      = baseATerm + idxTerm + dispAExt;
    sumB      = baseBTerm + dispBExt;
  end

  // register file, synchronous write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) gpr[i] <= '0;
    end else if (wrEn) begin
      gpr[wrIdx] <= wrData;
    end
  end

  // result stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opValid <= 1'b0;
      ssValid <= 1'b0;
      fmtOut  <= '0;
      addr1   <= '0;
      addr2   <= '0;
      rawSum  <= '0;
      lenOut  <= '0;
    end else begin
      opValid <= strb.addrValid;
      ssValid <= strb.dualAddr;
      if (strb.load) fmtOut <= strb.fmt;
      if (strb.dualAddr) begin
        addr1  <= sumA[ADDR_W-1:0];
        addr2  <= sumB[ADDR_W-1:0];
        rawSum <= sumB;
        lenOut <= instBody[39:32];
      end else if (strb.addrValid) begin
        addr2  <= sumA[ADDR_W-1:0];
        rawSum <= sumA;
      end
    end
  end

  // R10
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !opValid);

  // R8
  dual_implies_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ssValid |-> opValid);

  // R6
  addr_is_low_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> (addr2 == rawSum[ADDR_W-1:0]));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.addrValid |=> ($stable(addr2) && $stable(rawSum) && $stable(addr1)));

  // R4
  zero_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dualAddr && baseA == '0) |=> (addr1 == $past(dispAExt[ADDR_W-1:0])));
endmodule

// File: rtl/operand_addr_gen.sv
module operand_addr_gen
  import oag_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 24,
  parameter int NREGS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [REG_W-1:0]  wrData,
  input  logic              instValid,
  input  logic [47:0]       instWord,
  output logic              opValid,
  output logic              ssValid,
  output logic [1:0]        fmtOut,
  output logic [ADDR_W-1:0] addr1,
  output logic [ADDR_W-1:0] addr2,
  output logic [REG_W-1:0]  rawSum,
  output logic [7:0]        lenOut
);
  ctrl_s strb;

  oag_ctrl u_ctrl (
    .instValid (instValid),
    .opcode    (instWord[47:40]),
    .strb      (strb)
  );

  oag_dpath #(
    .REG_W  (REG_W),
    .ADDR_W (ADDR_W),
    .NREGS  (NREGS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .instBody (instWord[39:0]),
    .strb     (strb),
    .opValid  (opValid),
    .ssValid  (ssValid),
    .fmtOut   (fmtOut),
    .addr1    (addr1),
    .addr2    (addr2),
    .rawSum   (rawSum),
    .lenOut   (lenOut)
  );
endmodule

// File: tb/tb_operand_addr_gen.sv
`timescale 1ns/1ps
module tb_operand_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        instValid = 1'b0;
  logic [47:0] instWord = '0;
  logic        opValid, ssValid;
  logic [1:0]  fmtOut;
  logic [23:0] addr1, addr2;
  logic [31:0] rawSum;
  logic [7:0]  lenOut;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";
  string expTag = "R1";

  operand_addr_gen dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .instValid(instValid), .instWord(instWord), .opValid(opValid),
    .ssValid(ssValid), .fmtOut(fmtOut), .addr1(addr1), .addr2(addr2),
    .rawSum(rawSum), .lenOut(lenOut)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  int unsigned mreg [16];
  logic        eV = 0, eS = 0;
  logic [1:0]  eF = 0;
  logic [23:0] eA1 = 0, eA2 = 0;
  logic [31:0] eRaw = 0;
  logic [7:0]  eLen = 0;

  function automatic int unsigned regVal(input int n);
    return (n == 0) ? 0 : mreg[n];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      eV = 0; eS = 0; eF = 0; eA1 = 0; eA2 = 0; eRaw = 0; eLen = 0;
      foreach (mreg[i]) mreg[i] = 0;
    end else begin
      if (instValid) begin
        int f;
        int unsigned s1, s2;
        f  = int'(instWord[47:46]);
        eF = instWord[47:46];
        eV = (f != 0);
        eS = (f == 3);
        if (f == 3) begin
          s1 = regVal(int'(instWord[31:28])) + int'(instWord[27:16]);
          s2 = regVal(int'(instWord[15:12])) + int'(instWord[11:0]);
          eA1 = s1[23:0]; eA2 = s2[23:0]; eRaw = s2; eLen = instWord[39:32];
        end else if (f != 0) begin
          s1 = regVal(int'(instWord[31:28])) + int'(instWord[27:16]);
          if (f == 1) s1 = s1 + regVal(int'(instWord[35:32]));
          eA2 = s1[23:0]; eRaw = s1;
        end
      end else begin
        eV = 0; eS = 0;
      end
      if (wrEn) mreg[wrIdx] = wrData;
    end
    expTag = curTag;
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    checks++;
    if (opValid !== eV || ssValid !== eS || fmtOut !== eF || addr1 !== eA1 ||
        addr2 !== eA2 || rawSum !== eRaw || lenOut !== eLen) begin
      errors++;
      $display("FAIL %s: got v=%0b s=%0b f=%0d a1=%h a2=%h raw=%h len=%h exp v=%0b s=%0b f=%0d a1=%h a2=%h raw=%h len=%h",
               expTag, opValid, ssValid, fmtOut, addr1, addr2, rawSum, lenOut,
               eV, eS, eF, eA1, eA2, eRaw, eLen);
    end
  end

  task automatic putReg(input int n, input logic [31:0] v, input string tag);
    wrEn = 1; wrIdx = 4'(n); wrData = v; curTag = tag;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic putInst(input logic [47:0] w, input string tag);
    instValid = 1; instWord = w; curTag = tag;
    @(negedge clk);
    instValid = 0;
  endtask

  task automatic idle(input int n, input string tag);
    curTag = tag;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect24(input logic [23:0] act, input logic [23:0] exp, input string tag);
    #1;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic expect32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    #1;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  bit finished = 0;

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hang exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    idle(2, "R1");
    expect24(addr2, 24'h0, "R1");
    // R3: worked examples
    putReg(12, 32'h2500, "R11");
    putInst({32'h5840C123, 16'h0}, "R3");
    expect24(addr2, 24'h002623, "R3");
    putReg(7, 32'h300, "R11");
    putReg(11, 32'h124000, "R11");
    putInst({32'h58A7B125, 16'h0}, "R3");
    expect24(addr2, 24'h124425, "R3");
    // R4 / R5: register 0 holds a value but must add zero
    putReg(0, 32'h00001234, "R4");
    putInst({32'h58000FFF, 16'h0}, "R5");
    expect24(addr2, 24'h000FFF, "R5");
    putInst({32'h5800_0000, 16'h0}, "R4");
    expect24(addr2, 24'h000000, "R4");
    // R6: wrap past 24 and 32 bits
    putReg(3, 32'hFFFFFF00, "R6");
    putReg(4, 32'h00000200, "R6");
    putInst({32'h58134010, 16'h0}, "R6");
    expect32(rawSum, 32'h00000110, "R6");
    putReg(5, 32'h00FFFFF0, "R6");
    putInst({32'h58105020, 16'h0}, "R6");
    expect24(addr2, 24'h000010, "R6");
    expect32(rawSum, 32'h01000010, "R6");
    // R7: shift count and ignored second register nibble
    putInst({32'h89400001, 16'h0}, "R7");
    expect32(rawSum, 32'h00000001, "R7");
    putInst({32'h9857C100, 16'h0}, "R7");
    expect24(addr2, 24'h002600, "R7");
    // R8: storage-storage with both addresses
    putReg(4, 32'h8002, "R8");
    putInst(48'hD2014056409F, "R8");
    expect24(addr1, 24'h008058, "R8");
    expect24(addr2, 24'h0080A1, "R8");
    // R9: register-only and idle cycles hold results
    putInst({32'h1A34_0000, 16'h0}, "R9");
    expect24(addr2, 24'h0080A1, "R9");
    idle(2, "R9");
    // R10: back-to-back instructions then idle
    putInst({32'h5840C123, 16'h0}, "R10");
    putInst({32'h58A7B125, 16'h0}, "R10");
    idle(1, "R10");
    // R11: write and use in the same edge
    wrEn = 1; wrIdx = 4'd9; wrData = 32'h00ABC000;
    putInst({32'h58009004, 16'h0}, "R11");
    wrEn = 0;
    expect24(addr2, 24'h000004, "R11");
    putInst({32'h58009004, 16'h0}, "R11");
    expect24(addr2, 24'hABC004, "R11");
    // R2: random mix of formats, writes and gaps
    for (int i = 0; i < 400; i++) begin
      instValid = ($urandom_range(0, 3) != 0);
      instWord  = {$urandom(), 16'($urandom())};
      wrEn      = ($urandom_range(0, 2) == 0);
      wrIdx     = 4'($urandom_range(0, 15));
      wrData    = $urandom();
      curTag    = "R2";
      @(negedge clk);
    end
    instValid = 0; wrEn = 0;
    idle(3, "R9");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule